// File: doc/BRIEF.md
# Multi-Level Address Translation Walker

This block turns a 64-bit logical address into a real address by walking a tree of translation tables in memory. A request carries the logical address, the kind of access (read, store or instruction fetch), a two-bit address-space tag and the 64-bit address-space control word. Two plain control pins, sampled when a request is accepted, switch translation on and enable the extended table format. The control word picks the level at which the walk starts (first region, second region, third region or segment), gives the origin of that first table and the length of its window. The walker reads one 64-bit entry at a time through its memory port. It descends through region and segment entries to a page entry, or it stops at a segment entry that maps a 1 MB frame.

Every fetched entry is checked before it is used. The walker checks its invalid bit, its type field against the expected level, and the window of the next table. Read-only bits found along the path remove write permission. The walk ends with either a page-aligned real address or a fault code together with an exception word that a processor would record.

Requests and results move with valid/ready handshakes. The walker accepts a request only when idle (`req_ready` high). It holds every result field stable while `res_valid` is high and `res_ready` is low. On the memory port it holds `mem_req_valid` and the address until `mem_req_ready` is seen. It keeps at most one read in flight and takes `mem_rsp_valid` as a one-cycle pulse with no back-pressure.

Top module: `dat_walker`

## Requirements
- R1: `req_ready` is high exactly when no walk is in progress and no result is pending. After reset it is high, and `res_valid` and `mem_req_valid` are low. A result is held unchanged until the cycle in which `res_valid` and `res_ready` are both high.
- R2: When `dat_on` is low, or bit 5 of the control word (real-space) is set, the result is the logical address with bits 11:0 cleared, with code 0x00. No memory read is made.
- R3: The start level comes from control-word bits 3:2 (0 segment, 1 third region, 2 second region, 3 first region); level value L is that field times 4. The table origin is the word with bits 11:0 cleared. An entry is read at origin + ((vaddr >> (17 + 11*L/4)) & 0x3ff8).
- R4: Before any read, a second-region start needs vaddr bits 63:53 zero, a third-region start needs bits 63:42 zero, and a segment start needs bits 63:31 zero. Otherwise the code is 0x38.
- R5: The two index bits vaddr[63:62], [52:51], [41:40] or [30:29] (first region, second region, third region, segment start) must not exceed control-word bits 1:0. Otherwise the code of the start level is raised: 0x39, 0x3a, 0x3b or 0x10 respectively.
- R6: A region or segment entry with bit 5 set raises the code of the level being read (same mapping as R5). An entry whose bits 3:2 differ from that level raises 0x12.
- R7: For a valid region entry at level L, the index (vaddr >> (17 + 11*L/4)) & 3 must be at least entry bits 7:6 and at most entry bits 1:0. Otherwise the code of the next lower level is raised. If the index passes, the next table has origin entry[63:12].
- R8: A valid segment entry with bit 10 set while `edat_on` was high ends the walk with real address {entry[63:20], vaddr[19:12], 12'h000}. No page entry is read.
- R9: Otherwise the page entry is read at {segment[63:11], 11'b0} + vaddr[19:12]*8. If its bit 10 is set the code is 0x11; if its bit 11 is set the code is 0x12; if neither is set the real address is entry[63:12] with bits 11:0 zero.
- R10: Bit 9 of a page or segment entry, or of a region entry while extended format is on, removes write permission. A store that completes without write permission gets code 0x04. Reads and fetches are unaffected, and a translation fault takes precedence.
- R11: On any fault the exception word is the page-aligned vaddr OR 0x400 for a store or 0x800 otherwise (`req_kind` 1 = store, 0 = read, 2 = fetch), OR the address-space tag in bits 1:0, OR 0x4 for code 0x04. The real address is then 0. On success the word is 0.
- R12: A walk makes exactly one memory read per entry visited, never has two reads in flight, and holds the read address stable until `mem_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dat_on | input | 1 | Translation enable, sampled on request acceptance |
| edat_on | input | 1 | Extended table format enable, sampled on acceptance |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_vaddr | input | 64 | Logical address |
| req_kind | input | 2 | 0 read, 1 store, 2 fetch |
| req_space | input | 2 | Address-space tag for the exception word |
| req_asce | input | 64 | Address-space control word |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request taken |
| mem_req_addr | output | 64 | Doubleword read address |
| mem_rsp_valid | input | 1 | Read data valid (one-cycle pulse) |
| mem_rsp_data | input | 64 | Read data |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result taken |
| res_raddr | output | 64 | Real address (0 on fault) |
| res_code | output | 8 | Fault code, 0x00 on success |
| res_tec | output | 64 | Exception word (0 on success) |

## Verification
Two functions can end in the same decode cycle. The last entry completes the translation while its read-only bit makes a store fail protection, so the result must carry 0x04 and an exception word with 0x4 and 0x400, never the real address. A result can also sit in the output stage while the next request is already presented; that request must wait with `req_ready` low. The bench randomises read-only bits on every level together with store accesses, and stalls `res_ready` and `mem_req_ready` at random. It judges each walk against a reference model computed from the requirements, and checks `req_ready` right after every acceptance.

// File: rtl/dat_walk_pkg.sv
package dat_walk_pkg;

  localparam int unsigned VA_W     = 64;
  localparam int unsigned PG_SHIFT = 12;
  localparam int unsigned LVL_W    = 2;
  localparam int unsigned CODE_W   = 8;

  typedef enum logic [CODE_W-1:0] {
    XC_NONE  = 8'h00,
    XC_PROT  = 8'h04,
    XC_SEG   = 8'h10,
    XC_PAGE  = 8'h11,
    XC_SPEC  = 8'h12,
    XC_RANGE = 8'h38,
    XC_RGN1  = 8'h39,
    XC_RGN2  = 8'h3a,
    XC_RGN3  = 8'h3b
  } xcode_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } walk_st_e;

  // Translation fault of a table level (R5, R6)
  function automatic xcode_e lvl_code(input logic [LVL_W-1:0] lvl);
    case (lvl)
      2'd0:    return XC_SEG;
      2'd1:    return XC_RGN3;
      2'd2:    return XC_RGN2;
      default: return XC_RGN1;
    endcase
  endfunction

  // Byte offset of the entry in a level's table (R3)
  function automatic logic [VA_W-1:0] tbl_offset(input logic [VA_W-1:0] v,
                                                 input logic [LVL_W-1:0] lvl);
    case (lvl)
      2'd0:    return (v >> 17) & 64'h3ff8;
      2'd1:    return (v >> 28) & 64'h3ff8;
      2'd2:    return (v >> 39) & 64'h3ff8;
      default: return (v >> 50) & 64'h3ff8;
    endcase
  endfunction

  // Two-bit window index checked against a region entry (R7)
  function automatic logic [1:0] win_idx(input logic [VA_W-1:0] v,
                                         input logic [LVL_W-1:0] lvl);
    case (lvl)
      2'd0:    return v[18:17];
      2'd1:    return v[29:28];
      2'd2:    return v[40:39];
      default: return v[51:50];
    endcase
  endfunction

endpackage

// File: rtl/dat_root_check.sv
module dat_root_check
  import dat_walk_pkg::*;
(
  input  logic [VA_W-1:0]  vaddr,
  input  logic [VA_W-1:0]  asce,
  output logic             fault,
  output xcode_e           code,
  output logic [LVL_W-1:0] lvl,
  output logic [VA_W-1:0]  first_addr
);
  localparam int unsigned TL_W = 2;

  logic [TL_W-1:0] tl;
  logic [1:0]      top2;
  logic            range_bad;
  logic            unused_bits;

  assign lvl         = asce[3:2];
  assign tl          = asce[TL_W-1:0];
  assign unused_bits = ^{asce[11:4], vaddr[PG_SHIFT-1:0]};

  // R4: high address bits that the start level cannot reach
  always_comb begin
    case (lvl)
      2'd3:    range_bad = 1'b0;
      2'd2:    range_bad = |vaddr[63:53];
      2'd1:    range_bad = |vaddr[63:42];
      default: range_bad = |vaddr[63:31];
    endcase
  end

  // R5: first-level window against the table length
  always_comb begin
    case (lvl)
      2'd3:    top2 = vaddr[63:62];
      2'd2:    top2 = vaddr[52:51];
      2'd1:    top2 = vaddr[41:40];
      default: top2 = vaddr[30:29];
    endcase
  end

  always_comb begin
    fault = 1'b0;
    code  = XC_NONE;
    if (range_bad) begin
      fault = 1'b1;
      code  = XC_RANGE;
    end else if (top2 > tl) begin
      fault = 1'b1;
      code  = lvl_code(lvl);
    end
  end

  // R3: first entry address
  assign first_addr = {asce[VA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}} + tbl_offset(vaddr, lvl);

endmodule

// File: rtl/dat_entry_check.sv
module dat_entry_check
  import dat_walk_pkg::*;
(
  input  logic [VA_W-1:0]  ent,
  input  logic [LVL_W-1:0] lvl,
  input  logic             is_page,
  input  logic [VA_W-1:0]  vaddr,
  input  logic             edat,
  output logic             fault,
  output xcode_e           code,
  output logic             done,
  output logic [VA_W-1:0]  raddr,
  output logic             ro,
  output logic [VA_W-1:0]  next_addr,
  output logic [LVL_W-1:0] next_lvl,
  output logic             next_page
);
  localparam int unsigned B_INV_T  = 5;
  localparam int unsigned B_RO     = 9;
  localparam int unsigned B_LARGE  = 10;
  localparam int unsigned B_INV_P  = 10;
  localparam int unsigned B_RSV_P  = 11;
  localparam int unsigned SEG_ORG  = 11;
  localparam int unsigned LARGE_SH = 20;

  logic [1:0] widx;
  logic       unused_bits;

  assign widx        = win_idx(vaddr, lvl);
  assign unused_bits = ^{ent[8], ent[4], vaddr[PG_SHIFT-1:0]};

  always_comb begin
    fault     = 1'b0;
    code      = XC_NONE;
    done      = 1'b0;
    raddr     = '0;
    ro        = 1'b0;
    next_addr = '0;
    next_lvl  = lvl;
    next_page = 1'b0;
    if (is_page) begin
      // R9: page entry decode
      if (ent[B_INV_P]) begin
        fault = 1'b1;
        code  = XC_PAGE;
      end else if (ent[B_RSV_P]) begin
        fault = 1'b1;
        code  = XC_SPEC;
      end else begin
        done  = 1'b1;
        raddr = {ent[VA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
        ro    = ent[B_RO];
      end
    end else if (ent[B_INV_T]) begin
      // R6: invalid table entry
      fault = 1'b1;
      code  = lvl_code(lvl);
    end else if (ent[3:2] != lvl) begin
      fault = 1'b1;
      code  = XC_SPEC;
    end else if (lvl == '0) begin
      ro = ent[B_RO];
      if (ent[B_LARGE] && edat) begin
        // R8: 1 MB frame
        done  = 1'b1;
        raddr = {ent[VA_W-1:LARGE_SH], vaddr[LARGE_SH-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
      end else begin
        next_addr = {ent[VA_W-1:SEG_ORG], {SEG_ORG{1'b0}}}
                  + {{(VA_W-11){1'b0}}, vaddr[19:12], 3'b000};
        next_page = 1'b1;
      end
    end else if ((widx < ent[7:6]) || (widx > ent[1:0])) begin
      // R7: next table window
      fault = 1'b1;
      code  = lvl_code(lvl - 2'd1);
    end else begin
      ro        = edat & ent[B_RO];
      next_lvl  = lvl - 2'd1;
      next_addr = {ent[VA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}} + tbl_offset(vaddr, lvl - 2'd1);
    end
  end

endmodule

// File: rtl/dat_tec_build.sv
module dat_tec_build
  import dat_walk_pkg::*;
(
  input  logic [VA_W-1:0] vaddr,
  input  acc_e            kind,
  input  logic [1:0]      space,
  input  xcode_e          code,
  output logic [VA_W-1:0] tec
);
  localparam logic [VA_W-1:0] FS_LOAD  = 64'h800;
  localparam logic [VA_W-1:0] FS_STORE = 64'h400;
  localparam logic [VA_W-1:0] PROT_BIT = 64'h4;

  logic unused_bits;
  assign unused_bits = ^vaddr[PG_SHIFT-1:0];

  // R11: exception word
  always_comb begin
    if (code == XC_NONE) begin
      tec = '0;
    end else begin
      tec = {vaddr[VA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}}
          | ((kind == ACC_STORE) ? FS_STORE : FS_LOAD)
          | ((code == XC_PROT) ? PROT_BIT : '0)
          | {{(VA_W-2){1'b0}}, space};
    end
  end

endmodule

// File: rtl/dat_walker.sv
module dat_walker
  import dat_walk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dat_on,
  input  logic              edat_on,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_space,
  input  logic [VA_W-1:0]   req_asce,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [VA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [VA_W-1:0]   mem_rsp_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [VA_W-1:0]   res_raddr,
  output logic [CODE_W-1:0] res_code,
  output logic [VA_W-1:0]   res_tec
);
  localparam int unsigned B_REAL = 5;

  walk_st_e         st_q;
  logic [VA_W-1:0]  va_q, addr_q, raddr_q;
  acc_e             kind_q;
  logic [1:0]       space_q;
  logic [LVL_W-1:0] lvl_q;
  logic             pte_q, edat_q, wr_ok_q;
  xcode_e           code_q;

  logic [VA_W-1:0]  req_va_al;
  logic             rc_fault;
  xcode_e           rc_code;
  logic [LVL_W-1:0] rc_lvl;
  logic [VA_W-1:0]  rc_addr;

  logic             ec_fault, ec_done, ec_ro, ec_next_page;
  xcode_e           ec_code;
  logic [VA_W-1:0]  ec_raddr, ec_next_addr;
  logic [LVL_W-1:0] ec_next_lvl;
  logic             wr_next;
  logic             unused_bits;

  assign req_va_al   = {req_vaddr[VA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
  assign unused_bits = ^req_vaddr[PG_SHIFT-1:0];

  dat_root_check u_root (
    .vaddr      (req_va_al),
    .asce       (req_asce),
    .fault      (rc_fault),
    .code       (rc_code),
    .lvl        (rc_lvl),
    .first_addr (rc_addr)
  );

  dat_entry_check u_entry (
    .ent       (mem_rsp_data),
    .lvl       (lvl_q),
    .is_page   (pte_q),
    .vaddr     (va_q),
    .edat      (edat_q),
    .fault     (ec_fault),
    .code      (ec_code),
    .done      (ec_done),
    .raddr     (ec_raddr),
    .ro        (ec_ro),
    .next_addr (ec_next_addr),
    .next_lvl  (ec_next_lvl),
    .next_page (ec_next_page)
  );

  dat_tec_build u_tec (
    .vaddr (va_q),
    .kind  (kind_q),
    .space (space_q),
    .code  (code_q),
    .tec   (res_tec)
  );

  assign wr_next       = wr_ok_q & ~ec_ro;
  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_ISSUE);
  assign mem_req_addr  = addr_q;
  assign res_valid     = (st_q == ST_DONE);
  assign res_raddr     = raddr_q;
  assign res_code      = code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      va_q    <= '0;
      addr_q  <= '0;
      raddr_q <= '0;
      kind_q  <= ACC_READ;
      space_q <= '0;
      lvl_q   <= '0;
      pte_q   <= 1'b0;
      edat_q  <= 1'b0;
      wr_ok_q <= 1'b1;
      code_q  <= XC_NONE;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q    <= req_va_al;
            kind_q  <= acc_e'(req_kind);
            space_q <= req_space;
            edat_q  <= edat_on;
            wr_ok_q <= 1'b1;
            pte_q   <= 1'b0;
            if (!dat_on || req_asce[B_REAL]) begin
              // R2: direct mapping
              raddr_q <= req_va_al;
              code_q  <= XC_NONE;
              st_q    <= ST_DONE;
            end else if (rc_fault) begin
              raddr_q <= '0;
              code_q  <= rc_code;
              st_q    <= ST_DONE;
            end else begin
              addr_q <= rc_addr;
              lvl_q  <= rc_lvl;
              st_q   <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (mem_req_ready) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (ec_fault) begin
              raddr_q <= '0;
              code_q  <= ec_code;
              st_q    <= ST_DONE;
            end else if (ec_done) begin
              wr_ok_q <= wr_next;
              st_q    <= ST_DONE;
              if (kind_q == ACC_STORE && !wr_next) begin
                // R10: store without write permission
                raddr_q <= '0;
                code_q  <= XC_PROT;
              end else begin
                raddr_q <= ec_raddr;
                code_q  <= XC_NONE;
              end
            end else begin
              wr_ok_q <= wr_next;
              addr_q  <= ec_next_addr;
              lvl_q   <= ec_next_lvl;
              pte_q   <= ec_next_page;
              st_q    <= ST_ISSUE;
            end
          end
        end
        default: begin
          if (res_ready) st_q <= ST_IDLE;
        end
      endcase
    end
  end

  a_r1_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_raddr) && $stable(res_code)
                                && $stable(res_tec));

  a_r12_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r12_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  a_r11_prot_word: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_code == XC_PROT |-> res_tec[2] && res_tec[10] && !res_tec[11]);

  a_r11_ok_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_code == XC_NONE |-> res_tec == '0);

  a_r10_store_perm: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_code == XC_NONE && kind_q == ACC_STORE |-> wr_ok_q);

endmodule

// File: tb/tb_dat_walker.sv
module tb_dat_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dat_on = 1'b0, edat_on = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0, req_asce = '0;
  logic [1:0]  req_kind = '0, req_space = '0;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [63:0] res_raddr, res_tec;
  logic [7:0]  res_code;

  int total = 0, bad = 0;
  int nreads = 0;
  int ref_reads;
  logic [63:0] mem [logic [63:0]];

  localparam logic [63:0] PT_BASE = 64'h0000_00ab_cd50_0000;

  always #2 clk = ~clk;

  dat_walker dut (
    .clk(clk), .rst_n(rst_n), .dat_on(dat_on), .edat_on(edat_on),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_space(req_space), .req_asce(req_asce),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_raddr(res_raddr), .res_code(res_code), .res_tec(res_tec)
  );

  function automatic logic [63:0] peek(input logic [63:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'h20;
  endfunction

  function automatic logic [63:0] tbase(input int lv);
    return 64'h0000_0001_0000_0000 * 64'(lv + 1);
  endfunction

  function automatic logic [7:0] lcode(input int lv);
    case (lv)
      0: return 8'h10;
      1: return 8'h3b;
      2: return 8'h3a;
      default: return 8'h39;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Reference walk written from the requirements
  task automatic ref_walk(input logic [63:0] va_in, input logic [1:0] kind,
                          input logic [1:0] space, input logic [63:0] asce,
                          input logic dat, input logic edat,
                          output logic [7:0] code, output logic [63:0] ra,
                          output logic [63:0] tec, output string tag);
    logic [63:0] va, org, e, p;
    int lv;
    logic wr, fin;
    va = va_in & ~64'hfff; wr = 1'b1; code = 8'h00; ra = '0; ref_reads = 0;
    tag = "R3";
    if (!dat || asce[5]) begin
      ra = va; tag = "R2";
    end else begin
      lv = int'(asce[3:2]);
      if (lv != 3 && (va >> (31 + 11 * lv)) != 0) begin
        code = 8'h38; tag = "R4";
      end else if (((va >> (29 + 11 * lv)) & 64'h3) > 64'(asce[1:0])) begin
        code = lcode(lv); tag = "R5";
      end else begin
        org = asce & ~64'hfff; fin = 1'b0;
        while (!fin && code == 8'h00) begin
          e = peek(org + ((va >> (17 + 11 * lv)) & 64'h3ff8)); ref_reads++;
          if (e[5]) begin code = lcode(lv); tag = "R6"; end
          else if (int'(e[3:2]) != lv) begin code = 8'h12; tag = "R6"; end
          else if (lv == 0) begin
            if (e[9]) wr = 1'b0;
            if (e[10] && edat) begin
              ra = (e & ~64'hfffff) | (va & 64'hff000); tag = "R8";
            end else begin
              p = peek((e & ~64'h7ff) + ((va & 64'hff000) >> 9)); ref_reads++;
              tag = "R9";
              if (p[10]) code = 8'h11;
              else if (p[11]) code = 8'h12;
              else begin
                if (p[9]) wr = 1'b0;
                ra = p & ~64'hfff;
              end
            end
            fin = 1'b1;
          end else begin
            if (((va >> (17 + 11 * lv)) & 64'h3) < 64'(e[7:6]) ||
                ((va >> (17 + 11 * lv)) & 64'h3) > 64'(e[1:0])) begin
              code = lcode(lv - 1); tag = "R7";
            end else begin
              if (edat && e[9]) wr = 1'b0;
              org = e & ~64'hfff;
              lv--;
            end
          end
        end
        if (code == 8'h00 && kind == 2'd1 && !wr) begin code = 8'h04; tag = "R10"; end
      end
    end
    if (code != 8'h00) begin
      ra = '0;
      tec = va | ((kind == 2'd1) ? 64'h400 : 64'h800) | 64'(space)
          | ((code == 8'h04) ? 64'h4 : 64'h0);
    end else tec = '0;
  endtask

  // Build a chain of tables for va, with random defects on each entry
  task automatic build(input int t, input logic [63:0] va, input logic [1:0] tl,
                       output logic [63:0] asce);
    logic [63:0] a, e, p;
    int r;
    mem.delete();
    asce = tbase(t) | (64'(t) << 2) | 64'(tl);
    for (int lv = t; lv >= 0; lv--) begin
      a = tbase(lv) + ((va >> (17 + 11 * lv)) & 64'h3ff8);
      e = ((lv > 0) ? tbase(lv - 1) : PT_BASE) | (64'(lv) << 2) | 64'h3;
      r = int'($urandom % 20);
      case (r)
        0: e = e | 64'h20;
        1: e = e ^ 64'h4;
        2: e = (e & ~64'hc3) | 64'($urandom % 256 & 32'hc3);
        3, 6: e = e | 64'h200;
        4, 5: e = e | 64'h400;
        default: ;
      endcase
      mem[a] = e;
    end
    p = {$urandom, $urandom} & ~64'hfff;
    r = int'($urandom % 12);
    case (r)
      0: p = p | 64'h400;
      1: p = p | 64'h800;
      2, 3: p = p | 64'h200;
      default: ;
    endcase
    mem[PT_BASE + ((va & 64'hff000) >> 9)] = p;
  endtask

  // Memory model: random ready, random latency, one outstanding read
  initial begin
    logic pend;
    int dly;
    logic [63:0] paddr;
    pend = 1'b0; dly = 0; paddr = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        mem_req_ready = 1'b0;
        if (dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = peek(paddr);
          pend = 1'b0;
        end else dly--;
      end else if (mem_req_valid && ($urandom % 3 != 0)) begin
        mem_req_ready = 1'b1;
        paddr = mem_req_addr;
        pend = 1'b1;
        dly = int'($urandom % 3);
        nreads++;
      end else mem_req_ready = 1'b0;
    end
  end

  task automatic walk(input logic [63:0] va, input logic [1:0] kind, input logic [1:0] space,
                      input logic [63:0] asce, input logic dat, input logic edat);
    logic [7:0] ecode;
    logic [63:0] era, etec;
    string tag;
    int r0;
    logic [63:0] g_ra, g_tec;
    logic [7:0] g_code;
    ref_walk(va, kind, space, asce, dat, edat, ecode, era, etec, tag);
    @(negedge clk);
    req_vaddr = va; req_kind = kind; req_space = space; req_asce = asce;
    dat_on = dat; edat_on = edat; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    r0 = nreads;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 busy after accept", 64'(req_ready), 64'h0);
    forever begin
      res_ready = ($urandom % 2 == 0);
      if (res_valid && res_ready) break;
      @(negedge clk);
    end
    g_ra = res_raddr; g_code = res_code; g_tec = res_tec;
    @(negedge clk);
    res_ready = 1'b0;
    chk({tag, " code"}, 64'(g_code), 64'(ecode));
    chk({tag, " raddr"}, g_ra, era);
    chk("R11 tec", g_tec, etec);
    chk("R12 reads", 64'(nreads - r0), 64'(ref_reads));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] va, asce;
    logic [1:0]  tl;
    int t;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset req_ready", 64'(req_ready), 64'h1);
    chk("R1 reset res_valid", 64'(res_valid), 64'h0);
    chk("R12 reset mem_req_valid", 64'(mem_req_valid), 64'h0);

    // Directed: translation off keeps the page-aligned address (R2)
    walk(64'h1234_5678_9abc_def0, 2'd1, 2'd2, 64'h0, 1'b0, 1'b0);
    chk("R2 direct value", res_raddr, 64'h1234_5678_9abc_d000);

    // Sweep over start level, window length, access kind and entry defects
    for (int n = 0; n < 1600; n++) begin
      t  = n % 4;
      tl = ($urandom % 3 == 0) ? 2'($urandom % 4) : 2'd3;
      va = {$urandom, $urandom};
      if ($urandom % 8 != 0) begin
        case (t)
          2: va = va & ((64'h1 << 53) - 1);
          1: va = va & ((64'h1 << 42) - 1);
          0: va = va & ((64'h1 << 31) - 1);
          default: ;
        endcase
      end
      build(t, va, tl, asce);
      if ($urandom % 24 == 0) asce = asce | 64'h20;
      walk(va, 2'($urandom % 3), 2'($urandom % 4), asce,
           ($urandom % 24 != 0), 1'($urandom % 2));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule